// File: doc/BRIEF.md
# Receive Idle Timeout Monitor

This block watches a serial receiver's buffer and produces a one-cycle event when characters have been left unread for a programmable number of bit periods. Time is measured only on the receiver's per-bit baud tick, so the limit is expressed in bit times, not clock cycles. Any activity restarts the measurement: software taking a character out of the buffer, or the line delivering a new one. This matters when software asks to be woken only after several characters have collected. If the remote end stops short of that count, the level interrupt never arrives. The timeout then wakes software so that it can drain the leftovers.

The monitor counts only while three things hold: it is enabled, the buffer holds data, and the programmed limit is non-zero. Otherwise the count is held at zero. After the event fires, the monitor stays quiet until the next restart, so an untouched buffer produces one event and not a stream of them. If characters keep arriving just inside the limit, a level threshold of L is reached roughly (L − 1) × limit bit times after the first character.

Top module: `rx_idle_timer`

## Requirements
- R1: While reset is asserted, and on the first cycle after release, `timeout_o` is 0.
- R2: With `enable_i`=1, `fifo_nonempty_i`=1, `limit_i`=N (N≥1) and no restart, `timeout_o` is 1 in the clock cycle right after the edge that samples the N-th `bit_tick_i` since the last restart. It is 0 after each of the earlier ticks.
- R3: `timeout_o` is high for exactly one cycle. It stays low on every later tick until a restart occurs.
- R4: A cycle with `pop_i`=1 restarts the count at zero. N further ticks are then needed for the event.
- R5: A cycle with `push_i`=1 restarts the count at zero, in the same way as R4.
- R6: While `fifo_nonempty_i`=0, the count is held at zero and no event occurs. When data appears, N ticks are needed.
- R7: While `enable_i`=0, the count is held at zero and no event occurs. After enabling, N ticks are needed.
- R8: `limit_i`=0 disables the monitor. No event occurs and the count is held at zero.
- R9: Clock cycles without `bit_tick_i` do not advance the count.
- R10: If `limit_i` is lowered to or below the ticks already counted, the event fires on the next tick.
- R11: A restart in the same cycle as a tick wins. That tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_tick_i | input | 1 | One-cycle strobe, once per bit period |
| fifo_nonempty_i | input | 1 | Receive buffer holds at least one character |
| pop_i | input | 1 | Software removed a character |
| push_i | input | 1 | Line delivered a character into the buffer |
| enable_i | input | 1 | Monitor enable |
| limit_i | input | CNT_W | Timeout length in bit times; 0 disables |
| timeout_o | output | 1 | One-cycle timeout event |

## Verification
The tick is driven in three patterns: ticks back to back, sparse ticks separated by long tickless stretches, and ticks that land in the same cycle as a pop or push. Together these show that the count follows ticks rather than clock cycles, and that a restart takes priority over a simultaneous tick. The pop and push restarts are exercised separately, at a count one short of the limit, so an ignored restart would show up as an early event. The gating inputs (empty buffer, disable, zero limit) are each held through many ticks and then released, which separates "count held at zero" from "count frozen mid-way". A limit lowered below the elapsed count tells a greater-or-equal match apart from an exact-equality match.

// File: rtl/rxto_pkg.sv
`timescale 1ns/1ps
package rxto_pkg;
  typedef enum logic {
    TO_RUN   = 1'b0,
    TO_SPENT = 1'b1
  } to_phase_e;
endpackage

// File: rtl/rxto_gate.sv
`timescale 1ns/1ps
module rxto_gate #(
  parameter int CNT_W = 24
) (
  input  logic             enable_i,
  input  logic             fifo_nonempty_i,
  input  logic             pop_i,
  input  logic             push_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             restart_o
);
  logic armed;

  always_comb begin
    armed     = enable_i && fifo_nonempty_i && (limit_i != '0);
    restart_o = pop_i || push_i || !armed;
  end
endmodule

// File: rtl/rxto_counter.sv
`timescale 1ns/1ps
module rxto_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             advance_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_d, count_q;
  logic             count_en;

  always_comb begin
    count_en = restart_i || advance_i;
    count_d  = restart_i ? '0 : count_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/rxto_fire.sv
`timescale 1ns/1ps
module rxto_fire
  import rxto_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             bit_tick_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             advance_o,
  output logic             event_o
);
  localparam int EXT_W = CNT_W + 1;

  to_phase_e        phase_d, phase_q;
  logic             event_d, event_q;
  logic [EXT_W-1:0] next_cnt;
  logic             hit;

  always_comb begin
    advance_o = bit_tick_i && (phase_q == TO_RUN) && !restart_i;
    next_cnt  = {1'b0, count_i} + 1'b1;
    hit       = advance_o && (next_cnt >= {1'b0, limit_i});
    event_d   = hit;
    if (restart_i) begin
      phase_d = TO_RUN;
    end else if (hit) begin
      phase_d = TO_SPENT;
    end else begin
      phase_d = phase_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= TO_RUN;
      event_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      event_q <= event_d;
    end
  end

  assign event_o = event_q;
endmodule

// File: rtl/rx_idle_timer.sv
`timescale 1ns/1ps
module rx_idle_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_tick_i,
  input  logic             fifo_nonempty_i,
  input  logic             pop_i,
  input  logic             push_i,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             timeout_o
);
  logic             restart;
  logic             advance;
  logic [CNT_W-1:0] count;

  rxto_gate #(.CNT_W(CNT_W)) u_gate (
    .enable_i        (enable_i),
    .fifo_nonempty_i (fifo_nonempty_i),
    .pop_i           (pop_i),
    .push_i          (push_i),
    .limit_i         (limit_i),
    .restart_o       (restart)
  );

  rxto_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .advance_i (advance),
    .count_o   (count)
  );

  rxto_fire #(.CNT_W(CNT_W)) u_fire (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart),
    .bit_tick_i (bit_tick_i),
    .count_i    (count),
    .limit_i    (limit_i),
    .advance_o  (advance),
    .event_o    (timeout_o)
  );
endmodule

// File: rtl/rx_idle_timer_checker.sv
`timescale 1ns/1ps
module rx_idle_timer_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_tick_i,
  input logic             fifo_nonempty_i,
  input logic             pop_i,
  input logic             push_i,
  input logic             enable_i,
  input logic [CNT_W-1:0] limit_i,
  input logic             timeout_o
);
  assert_quiet_in_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !timeout_o);

  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  assert_pop_restarts_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> !timeout_o);

  assert_push_restarts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> !timeout_o);

  assert_needs_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_nonempty_i |=> !timeout_o);

  assert_needs_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !timeout_o);

  assert_zero_limit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_i == '0) |=> !timeout_o);

  assert_tick_driven_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> !timeout_o);
endmodule

bind rx_idle_timer rx_idle_timer_checker #(.CNT_W(CNT_W)) u_checker (.*);

// File: tb/rx_idle_timer_test.sv
`timescale 1ns/1ps
module rx_idle_timer_test;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         bit_tick_i = 1'b0;
  logic         fifo_nonempty_i = 1'b0;
  logic         pop_i = 1'b0;
  logic         push_i = 1'b0;
  logic         enable_i = 1'b0;
  logic [W-1:0] limit_i = '0;
  logic         timeout_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  rx_idle_timer #(.CNT_W(W)) uut (.*);

  task automatic check(input logic got, input logic exp, input string req);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: timeout_o=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // one tick, optionally with pop/push in the same cycle; returns the output after the edge
  task automatic tick(output logic seen, input logic with_pop = 1'b0, input logic with_push = 1'b0);
    @(negedge clk_i);
    bit_tick_i = 1'b1; pop_i = with_pop; push_i = with_push;
    @(posedge clk_i); #1;
    seen = timeout_o;
    @(negedge clk_i);
    bit_tick_i = 1'b0; pop_i = 1'b0; push_i = 1'b0;
  endtask

  task automatic strobe(input logic p, input logic q);
    @(negedge clk_i);
    pop_i = p; push_i = q;
    @(negedge clk_i);
    pop_i = 1'b0; push_i = 1'b0;
  endtask

  // n ticks that must all stay quiet
  task automatic quiet_ticks(input int n, input string req);
    logic s;
    for (int i = 0; i < n; i++) begin
      tick(s);
      check(s, 1'b0, req);
    end
  endtask

  task automatic setup(input int lim);
    limit_i = lim[W-1:0]; enable_i = 1'b1; fifo_nonempty_i = 1'b1;
    strobe(1'b1, 1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check(timeout_o, 1'b0, "R1 in reset");
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check(timeout_o, 1'b0, "R1 after release");
  endtask

  task automatic t_basic();
    logic s;
    setup(5);
    quiet_ticks(4, "R2 early");
    tick(s); check(s, 1'b1, "R2 fifth tick");
    @(posedge clk_i); #1; check(timeout_o, 1'b0, "R3 one cycle");
    quiet_ticks(6, "R3 no repeat");
  endtask

  task automatic t_pop();
    logic s;
    setup(5);
    quiet_ticks(4, "R4 before pop");
    strobe(1'b1, 1'b0);
    quiet_ticks(4, "R4 after pop");
    tick(s); check(s, 1'b1, "R4 full count after pop");
  endtask

  task automatic t_push();
    logic s;
    setup(5);
    quiet_ticks(4, "R5 before push");
    strobe(1'b0, 1'b1);
    quiet_ticks(4, "R5 after push");
    tick(s); check(s, 1'b1, "R5 full count after push");
  endtask

  task automatic t_empty();
    logic s;
    setup(3);
    fifo_nonempty_i = 1'b0;
    quiet_ticks(10, "R6 empty");
    fifo_nonempty_i = 1'b1;
    quiet_ticks(2, "R6 refill");
    tick(s); check(s, 1'b1, "R6 full count after refill");
  endtask

  task automatic t_enable();
    logic s;
    setup(3);
    quiet_ticks(2, "R7 partial");
    enable_i = 1'b0;
    quiet_ticks(10, "R7 disabled");
    enable_i = 1'b1;
    quiet_ticks(2, "R7 reenabled");
    tick(s); check(s, 1'b1, "R7 full count after enable");
  endtask

  task automatic t_zero();
    logic s;
    setup(0);
    quiet_ticks(20, "R8 zero limit");
    limit_i = 2;
    quiet_ticks(1, "R8 after limit set");
    tick(s); check(s, 1'b1, "R8 count held at zero");
  endtask

  task automatic t_notick();
    logic s;
    setup(2);
    quiet_ticks(1, "R9 first tick");
    repeat (30) begin
      @(posedge clk_i); #1;
      check(timeout_o, 1'b0, "R9 tickless cycle");
    end
    tick(s); check(s, 1'b1, "R9 second tick");
  endtask

  task automatic t_lower();
    logic s;
    setup(10);
    quiet_ticks(6, "R10 before lowering");
    limit_i = 3;
    tick(s); check(s, 1'b1, "R10 lowered limit");
  endtask

  task automatic t_coincide();
    logic s;
    setup(3);
    quiet_ticks(2, "R11 before");
    tick(s, 1'b1, 1'b0); check(s, 1'b0, "R11 tick with pop");
    quiet_ticks(2, "R11 after pop");
    tick(s); check(s, 1'b1, "R11 third tick");
    setup(3);
    quiet_ticks(2, "R11 before push");
    tick(s, 1'b0, 1'b1); check(s, 1'b0, "R11 tick with push");
    quiet_ticks(2, "R11 after push");
    tick(s); check(s, 1'b1, "R11 third tick after push");
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    t_reset();
    t_basic();
    t_pop();
    t_push();
    t_empty();
    t_enable();
    t_zero();
    t_notick();
    t_lower();
    t_coincide();
    finished = 1'b1;
    summary();
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      summary();
    end
  end
endmodule